// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the architectural update a processor core makes when it takes an exception. It accepts one request. The request carries a five-bit exception code, the faulting PC, a two-bit branch state and the faulting instruction word. From these it builds the new cause, status and exception-PC values. It also produces the fetch redirect address and a one-cycle strobe that tells the pipeline to load all of them.

A request is accepted only when the unit is idle. The FSM has three states:

- **IDLE**: waiting for a request.
- **DRAIN**: entered when a delayed load write-back is still pending at accept time. The unit asks for the load to finish and waits until it has.
- **COMMIT**: registers the new values and raises the strobe.

The transitions are:

- IDLE to COMMIT, on a request with no pending load.
- IDLE to DRAIN, on a request with a pending load.
- DRAIN to DRAIN, while the load is still pending.
- DRAIN to COMMIT, once the load has finished.
- COMMIT to IDLE, always.

The cause value keeps only the two software-interrupt bits of the old value. The status value shifts its three-level kernel/user and interrupt-enable stack up by one level. The exception PC steps back one instruction for a fault in a branch delay slot.

Top module: `exc_entry`

## Requirements
- R1: After reset, `redir_valid`, `busy` and `ld_drain` are 0, and `cause_out`, `status_out`, `epc_out` and `redir_pc` are 0.
- R2: `cause_out[9:8]` equals the old cause bits 9:8 sampled at accept. `cause_out[6:2]` equals the exception code. Bits 27:10, 7 and 1:0 of `cause_out` are 0.
- R3: `cause_out[31:30]` equals the two-bit branch state sampled at accept.
- R4: When `insn_src` is 1 at accept, `cause_out[29:28]` equals instruction bits 27:26. When `insn_src` is 0, these bits are 0.
- R5: `status_out[5:0]` equals old status bits 3:0 shifted left by 2, with bits 1:0 equal to 0. `status_out[31:6]` equals the old status bits 31:6.
- R6: `epc_out` equals the faulting PC minus 4 when the branch state is nonzero. Otherwise it equals the faulting PC.
- R7: `redir_pc` is 0x80000040 for exception code 9 (breakpoint) and 0x80000080 for every other code.
- R8: With no pending load, `redir_valid` is high for exactly one cycle. That cycle is the second clock after the accepting edge, and all outputs hold their values afterwards.
- R9: If `ld_pend` is 1 at accept, `ld_drain` is high and `redir_valid` stays low for as long as `ld_pend` stays high. `redir_valid` rises on the second clock edge after `ld_pend` falls.
- R10: A request raised while `busy` is 1 is ignored. No extra strobe appears, and the committed values belong to the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request, accepted when idle |
| exc_code | input | 5 | Exception code |
| exc_pc | input | 32 | Faulting PC |
| br_state | input | 2 | Branch-delay state, nonzero inside a delay slot |
| insn_src | input | 1 | Exception was caused by the instruction; capture coprocessor number |
| insn_word | input | 32 | Faulting instruction word |
| cause_in | input | 32 | Current cause register |
| status_in | input | 32 | Current status register |
| ld_pend | input | 1 | Delayed load write-back pending |
| busy | output | 1 | Unit is not idle |
| ld_drain | output | 1 | Request to complete the pending load |
| cause_out | output | 32 | New cause value |
| status_out | output | 32 | New status value |
| epc_out | output | 32 | Saved exception PC |
| redir_pc | output | 32 | Fetch redirect address |
| redir_valid | output | 1 | One-cycle strobe loading the new state |

## Verification
The bench sweeps every exception code against every branch state, with and without instruction-word capture. Old cause, status, PC and instruction words come from a pseudo-random generator, so every field is checked under changing neighbours.

The sweep has several purposes:
- The code sweep separates the breakpoint vector from the general one.
- The branch-state sweep shows which states move the exception PC.
- The capture flag shows whether the coprocessor bits come from the instruction.
- Random old cause bits expose any bit that leaks through other than the kept pair.

Separate patterns hold the pending-load line high for several cycles and pulse a second request mid-sequence. These tell the drain wait and the busy lockout apart from the plain two-cycle path.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_COMMIT = 2'd2
    } exc_state_t;

    typedef struct packed {
        logic [4:0]  code;
        logic [31:0] pc;
        logic [1:0]  br;
        logic        use_insn;
        logic [1:0]  cop;
        logic [1:0]  swi;
        logic [31:0] status;
    } exc_req_t;
endpackage

// File: rtl/exc_cause_fmt.sv
module exc_cause_fmt #(
    parameter int CODE_W = 5
) (
    input  logic [1:0]        swi_keep,
    input  logic [CODE_W-1:0] code,
    input  logic [1:0]        br,
    input  logic              use_insn,
    input  logic [1:0]        cop,
    output logic [31:0]       cause
);
    localparam int CODE_LO = 2;
    localparam int SWI_LO  = 8;
    always_comb begin
        cause = '0;
        cause[SWI_LO +: 2]      = swi_keep;
        cause[CODE_LO +: CODE_W] = code;
        cause[31:30]            = br;
        cause[29:28]            = use_insn ? cop : 2'b00;
    end
endmodule

// File: rtl/exc_mode_stack.sv
module exc_mode_stack #(
    parameter int LEVELS = 3
) (
    input  logic [31:0] old_status,
    output logic [31:0] new_status
);
    localparam int STK_W = 2 * LEVELS;
    logic unused_top;
    assign unused_top = ^old_status[STK_W-1:STK_W-2];
    always_comb begin
        new_status = old_status;
        new_status[STK_W-1:0] = {old_status[STK_W-3:0], 2'b00};
    end
endmodule

// File: rtl/exc_epc_vec.sv
module exc_epc_vec #(
    parameter int          CODE_W  = 5,
    parameter int          BP_CODE = 9,
    parameter logic [31:0] VEC_BP  = 32'h8000_0040,
    parameter logic [31:0] VEC_GEN = 32'h8000_0080
) (
    input  logic [31:0]       pc,
    input  logic [1:0]        br,
    input  logic [CODE_W-1:0] code,
    output logic [31:0]       epc,
    output logic [31:0]       vec
);
    localparam logic [CODE_W-1:0] BP_C = CODE_W'(BP_CODE);
    assign epc = (br != 2'b00) ? pc - 32'd4 : pc;
    assign vec = (code == BP_C) ? VEC_BP : VEC_GEN;
endmodule

// File: rtl/exc_entry.sv
module exc_entry
    import exc_pkg::*;
#(
    parameter int          CODE_W  = 5,
    parameter int          BP_CODE = 9,
    parameter logic [31:0] VEC_BP  = 32'h8000_0040,
    parameter logic [31:0] VEC_GEN = 32'h8000_0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [31:0]       exc_pc,
    input  logic [1:0]        br_state,
    input  logic              insn_src,
    input  logic [31:0]       insn_word,
    input  logic [31:0]       cause_in,
    input  logic [31:0]       status_in,
    input  logic              ld_pend,
    output logic              busy,
    output logic              ld_drain,
    output logic [31:0]       cause_out,
    output logic [31:0]       status_out,
    output logic [31:0]       epc_out,
    output logic [31:0]       redir_pc,
    output logic              redir_valid
);
    exc_state_t state, nxt;
    exc_req_t   held;
    logic [31:0] n_cause, n_status, n_epc, n_vec;
    logic accept;

    logic unused_inputs;
    assign unused_inputs = ^{insn_word[31:28], insn_word[25:0],
                             cause_in[31:10], cause_in[7:0]};

    assign accept = (state == ST_IDLE) && exc_req;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (exc_req) nxt = ld_pend ? ST_DRAIN : ST_COMMIT;
            ST_DRAIN:  if (!ld_pend) nxt = ST_COMMIT;
            ST_COMMIT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (accept) begin
            held.code     <= exc_code;
            held.pc       <= exc_pc;
            held.br       <= br_state;
            held.use_insn <= insn_src;
            held.cop      <= insn_word[27:26];
            held.swi      <= cause_in[9:8];
            held.status   <= status_in;
        end
    end

    exc_cause_fmt #(.CODE_W(CODE_W)) u_cause (
        .swi_keep (held.swi),
        .code     (held.code),
        .br       (held.br),
        .use_insn (held.use_insn),
        .cop      (held.cop),
        .cause    (n_cause)
    );

    exc_mode_stack #(.LEVELS(3)) u_stack (
        .old_status (held.status),
        .new_status (n_status)
    );

    exc_epc_vec #(
        .CODE_W(CODE_W), .BP_CODE(BP_CODE), .VEC_BP(VEC_BP), .VEC_GEN(VEC_GEN)
    ) u_epc (
        .pc   (held.pc),
        .br   (held.br),
        .code (held.code),
        .epc  (n_epc),
        .vec  (n_vec)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_out   <= '0;
            status_out  <= '0;
            epc_out     <= '0;
            redir_pc    <= '0;
            redir_valid <= 1'b0;
        end else begin
            redir_valid <= (state == ST_COMMIT);
            if (state == ST_COMMIT) begin
                cause_out  <= n_cause;
                status_out <= n_status;
                epc_out    <= n_epc;
                redir_pc   <= n_vec;
            end
        end
    end

    assign busy     = (state != ST_IDLE);
    assign ld_drain = (state == ST_DRAIN);
endmodule

module exc_entry_chk #(
    parameter int CODE_W  = 5,
    parameter int BP_CODE = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_req,
    input logic [CODE_W-1:0] exc_code,
    input logic [31:0]       exc_pc,
    input logic [1:0]        br_state,
    input logic              insn_src,
    input logic [31:0]       insn_word,
    input logic [31:0]       cause_in,
    input logic [31:0]       status_in,
    input logic              ld_pend,
    input logic              busy,
    input logic              ld_drain,
    input logic [31:0]       cause_out,
    input logic [31:0]       status_out,
    input logic [31:0]       epc_out,
    input logic [31:0]       redir_pc,
    input logic              redir_valid
);
    logic [CODE_W-1:0] c_code;
    logic [31:0] c_pc, c_status;
    logic [1:0]  c_br, c_cop, c_swi;
    logic        c_ins;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_code <= '0; c_pc <= '0; c_status <= '0;
            c_br <= '0; c_cop <= '0; c_swi <= '0; c_ins <= 1'b0;
        end else if (exc_req && !busy) begin
            c_code <= exc_code; c_pc <= exc_pc; c_status <= status_in;
            c_br <= br_state; c_cop <= insn_word[27:26];
            c_swi <= cause_in[9:8]; c_ins <= insn_src;
        end
    end

    // R2
    swi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (cause_out[9:8] == c_swi && cause_out[6:2] == c_code
                         && cause_out[27:10] == '0 && cause_out[7] == 1'b0
                         && cause_out[1:0] == 2'b00));
    // R3
    br_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> cause_out[31:30] == c_br);
    // R4
    cop_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> cause_out[29:28] == (c_ins ? c_cop : 2'b00));
    // R5
    mode_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (status_out[5:0] == {c_status[3:0], 2'b00}
                         && status_out[31:6] == c_status[31:6]));
    // R6
    epc_adj_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> epc_out == (c_br != 2'b00 ? c_pc - 32'd4 : c_pc));
    // R7
    vector_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> redir_pc == ((c_code == CODE_W'(BP_CODE)) ? 32'h8000_0040 : 32'h8000_0080));
    // R8
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid);
    // R9
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_drain && ld_pend) |=> (!redir_valid && ld_drain));
endmodule

bind exc_entry exc_entry_chk #(.CODE_W(CODE_W), .BP_CODE(BP_CODE)) u_chk (.*);

// File: tb/tb_exc_entry.sv
module tb_exc_entry;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exc_req = 1'b0;
    logic [4:0] exc_code = '0;
    logic [31:0] exc_pc = '0;
    logic [1:0] br_state = '0;
    logic insn_src = 1'b0;
    logic [31:0] insn_word = '0;
    logic [31:0] cause_in = '0;
    logic [31:0] status_in = '0;
    logic ld_pend = 1'b0;
    logic busy, ld_drain, redir_valid;
    logic [31:0] cause_out, status_out, epc_out, redir_pc;

    int checks = 0;
    int errors = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    exc_entry dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt_rng(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    logic [4:0]  e_code;
    logic [31:0] e_pc, e_insn, e_cause, e_status;
    logic [1:0]  e_br;
    logic        e_ins;

    task automatic drive(input logic [4:0] c, input logic [1:0] b, input logic i);
        rng = nxt_rng(rng); e_pc = {rng[31:2], 2'b00};
        rng = nxt_rng(rng); e_insn = rng;
        rng = nxt_rng(rng); e_cause = rng;
        rng = nxt_rng(rng); e_status = rng;
        e_code = c; e_br = b; e_ins = i;
        exc_code = c; br_state = b; insn_src = i;
        exc_pc = e_pc; insn_word = e_insn; cause_in = e_cause; status_in = e_status;
        exc_req = 1'b1;
    endtask

    task automatic check_outputs();
        logic [31:0] ec;
        ec = '0;
        ec[9:8] = e_cause[9:8];
        ec[6:2] = e_code;
        ec[31:30] = e_br;
        ec[29:28] = e_ins ? e_insn[27:26] : 2'b00;
        chk("R2 cause code/swi", {cause_out[27:0]}, {ec[27:0]});
        chk("R3 cause branch", {30'd0, cause_out[31:30]}, {30'd0, e_br});
        chk("R4 cause cop", {30'd0, cause_out[29:28]}, {30'd0, ec[29:28]});
        chk("R5 status", status_out, {e_status[31:6], e_status[3:0], 2'b00});
        chk("R6 epc", epc_out, (e_br != 0) ? e_pc - 32'd4 : e_pc);
        chk("R7 vector", redir_pc, (e_code == 5'd9) ? 32'h8000_0040 : 32'h8000_0080);
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", {31'd0, redir_valid}, 32'd0);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 drain", {31'd0, ld_drain}, 32'd0);
        chk("R1 cause", cause_out, 32'd0);
        chk("R1 status", status_out, 32'd0);
        chk("R1 epc", epc_out, 32'd0);
        chk("R1 vector", redir_pc, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: every code x branch state x capture flag, plain path
        for (int c = 0; c < 32; c++) begin
            for (int b = 0; b < 4; b++) begin
                for (int i = 0; i < 2; i++) begin
                    drive(c[4:0], b[1:0], i[0]);
                    @(negedge clk);
                    exc_req = 1'b0;
                    chk("R8 not yet valid", {31'd0, redir_valid}, 32'd0);
                    @(negedge clk);
                    chk("R8 valid", {31'd0, redir_valid}, 32'd1);
                    check_outputs();
                    @(negedge clk);
                    chk("R8 single pulse", {31'd0, redir_valid}, 32'd0);
                    chk("R8 hold epc", epc_out, (e_br != 0) ? e_pc - 32'd4 : e_pc);
                end
            end
        end

        // Drain path with a request during busy (R9, R10)
        for (int k = 0; k < 4; k++) begin
            ld_pend = 1'b1;
            drive(5'd9 + k[4:0], k[1:0], 1'b1);
            @(negedge clk);
            exc_req = 1'b0;
            for (int w = 0; w < 3 + k; w++) begin
                chk("R9 drain high", {31'd0, ld_drain}, 32'd1);
                chk("R9 no strobe", {31'd0, redir_valid}, 32'd0);
                if (w == 1) begin
                    exc_code = 5'd3; br_state = 2'd0; exc_pc = 32'hDEAD_BEE0;
                    status_in = 32'h0; cause_in = 32'h0; exc_req = 1'b1;
                end else begin
                    exc_req = 1'b0;
                end
                @(negedge clk);
            end
            exc_req = 1'b0;
            ld_pend = 1'b0;
            @(negedge clk);
            chk("R9 drain cleared", {31'd0, ld_drain}, 32'd0);
            chk("R9 not yet", {31'd0, redir_valid}, 32'd0);
            @(negedge clk);
            chk("R9 valid after drain", {31'd0, redir_valid}, 32'd1);
            check_outputs();
            for (int q = 0; q < 4; q++) begin
                @(negedge clk);
                chk("R10 no second strobe", {31'd0, redir_valid}, 32'd0);
                chk("R10 busy idle", {31'd0, busy}, 32'd0);
            end
            chk("R10 first request kept", epc_out, (e_br != 0) ? e_pc - 32'd4 : e_pc);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule